// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block decides conditional branches for a 32-bit in-order core that fetches ahead through a prefetch queue. Each issued branch carries a five-bit option field, a condition-bit index and a target kind. The kind is pc-relative, the return-address register, or the loop-count register. The unit reads the live condition bits, count register and return-address register, each with its own ready flag. It reports whether the branch is taken, where it goes, and whether the count register must be rewritten with its decremented value.

When everything the branch needs is ready, the answer is registered one cycle after issue. When only the condition is still pending, the unit issues a static guess from the hint bit so fetch can continue. It then waits. On resolution, if the guess was wrong, it raises a one-cycle flush with the correct fetch address. When the register target itself is not yet ready, the unit makes no guess. It holds `stall` high until the value arrives.

Option fields that use don't-care positions execute exactly as the defined form with those positions cleared. Every form is resolved in hardware.

Top module: `cbr_unit`

## Requirements
- R1: Option bit 4 set means the condition is ignored. Otherwise the condition test passes when `cr_bits[bi]` (bit 0 is the LSB) equals option bit 3.
- R2: Option bit 2 clear means decrement. `ctr_we` is then 1, `ctr_next` = `ctr_val`-1, and the count test passes when (`ctr_val`-1 == 0) equals option bit 1. The branch is taken only when both the count test and the condition test pass, and a disabled test counts as passing.
- R3: Don't-care positions have no effect. Option bit 3 is cleared when bit 4 is set, bit 1 is cleared when bit 2 is set, and bit 0 is cleared when bits 4 and 2 are both set.
- R4: The target is `fetch_pc`+`disp` for kind 2'b00 (and 2'b11), `lr_val` for kind 2'b01, and `ctr_val` for kind 2'b10. In every case the two low bits are cleared.
- R5: A count-kind branch that also decrements targets the decremented count value.
- R6: An issued branch whose condition, count and target are all ready gives `res_valid` high for one cycle, on the cycle after issue, with no prediction.
- R7: If the condition is not ready (or a decrement awaits the count) but the target is ready, `pred_valid` pulses one cycle after issue. `pred_taken` then equals option bit 0, and `pred_addr` is the target if the hint is taken, otherwise `fetch_pc`+4.
- R8: If a return-address or count target is not ready, `stall` is high and no prediction is made until the value becomes ready.
- R9: When a predicted branch resolves against its guess, `flush` pulses in the same cycle as `res_valid`. `flush_addr` is then the target if taken, otherwise `fetch_pc`+4. When the guess was right, `flush` stays low.
- R10: After reset, `busy`, `stall`, `res_valid`, `pred_valid`, `ctr_we` and `flush` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | A branch is offered this cycle (taken only when not busy) |
| bo_raw | input | 5 | Branch option field |
| bi | input | 5 | Condition bit index |
| kind | input | 2 | Target kind: 00 relative, 01 return address, 10 count |
| fetch_pc | input | 32 | Address of the branch |
| disp | input | 32 | Relative displacement |
| cr_bits | input | 32 | Condition bits |
| cr_ready | input | 1 | Condition bits valid |
| ctr_val | input | 32 | Count register |
| ctr_ready | input | 1 | Count register valid |
| lr_val | input | 32 | Return-address register |
| lr_ready | input | 1 | Return-address register valid |
| busy | output | 1 | A branch is pending |
| stall | output | 1 | Waiting for a register target |
| res_valid | output | 1 | Resolution pulse |
| res_taken | output | 1 | Taken decision |
| res_target | output | 32 | Aligned branch target |
| ctr_we | output | 1 | Count register write enable |
| ctr_next | output | 32 | Decremented count value |
| pred_valid | output | 1 | Prediction pulse |
| pred_taken | output | 1 | Predicted direction |
| pred_addr | output | 32 | Predicted fetch address |
| flush | output | 1 | Mispredict pulse |
| flush_addr | output | 32 | Corrected fetch address |

## Verification
Two functions meet in one cycle: resolving a predicted branch and correcting its guess. The flush has to appear alongside the result, not a cycle later. The bench provokes this by issuing a branch with the condition unready, then releasing the condition with the value opposite to the hint, in both directions. In that single sampled cycle it checks the taken decision, the flush pulse and the corrected address together. It also checks that a correct guess leaves the flush low.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    BK_REL = 2'b00,
    BK_LNK = 2'b01,
    BK_CNT = 2'b10,
    BK_RSV = 2'b11
  } br_kind_e;

  typedef struct packed {
    logic skip_cond;
    logic sense;
    logic keep_ctr;
    logic on_zero;
    logic hint;
  } bo_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_TGT  = 2'b01,
    ST_PRED = 2'b10
  } st_e;
endpackage

// File: rtl/cbr_bo_decode.sv
module cbr_bo_decode
  import cbr_pkg::*;
(
  input  logic [4:0] raw,
  output bo_t        f
);
  // don't-care positions forced to zero so invalid forms act as defined ones
  always_comb begin
    f.skip_cond = raw[4];
    f.sense     = raw[4] ? 1'b0 : raw[3];
    f.keep_ctr  = raw[2];
    f.on_zero   = raw[2] ? 1'b0 : raw[1];
    f.hint      = (raw[4] & raw[2]) ? 1'b0 : raw[0];
  end
endmodule

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
  import cbr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CRW  = 32,
  localparam int BIW = $clog2(CRW)
) (
  input  bo_t             f,
  input  logic [BIW-1:0]  bi,
  input  logic [CRW-1:0]  cr,
  input  logic [XLEN-1:0] ctr,
  output logic [XLEN-1:0] ctr_dec,
  output logic            taken
);
  logic cond_ok, cnt_ok;
  always_comb begin
    ctr_dec = ctr - XLEN'(1);
    cnt_ok  = f.keep_ctr | ((ctr_dec == '0) == f.on_zero);
    cond_ok = f.skip_cond | (cr[bi] == f.sense);
    taken   = cnt_ok & cond_ok;
  end
endmodule

// File: rtl/cbr_target_sel.sv
module cbr_target_sel
  import cbr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int ALIGN = 2
) (
  input  br_kind_e        kind,
  input  logic            keep_ctr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] disp,
  input  logic [XLEN-1:0] lr,
  input  logic [XLEN-1:0] ctr,
  input  logic [XLEN-1:0] ctr_dec,
  output logic [XLEN-1:0] tgt
);
  localparam logic [XLEN-1:0] MASK = ~((XLEN'(1) << ALIGN) - XLEN'(1));
  logic [XLEN-1:0] raw;
  always_comb begin
    unique case (kind)
      BK_LNK:  raw = lr;
      BK_CNT:  raw = keep_ctr ? ctr : ctr_dec;
      default: raw = pc + disp;
    endcase
    tgt = raw & MASK;
  end
endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
  import cbr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CRW   = 32,
  parameter int IBYTES = 4,
  localparam int BIW  = $clog2(CRW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_valid,
  input  logic [4:0]      bo_raw,
  input  logic [BIW-1:0]  bi,
  input  logic [1:0]      kind,
  input  logic [XLEN-1:0] fetch_pc,
  input  logic [XLEN-1:0] disp,
  input  logic [CRW-1:0]  cr_bits,
  input  logic            cr_ready,
  input  logic [XLEN-1:0] ctr_val,
  input  logic            ctr_ready,
  input  logic [XLEN-1:0] lr_val,
  input  logic            lr_ready,
  output logic            busy,
  output logic            stall,
  output logic            res_valid,
  output logic            res_taken,
  output logic [XLEN-1:0] res_target,
  output logic            ctr_we,
  output logic [XLEN-1:0] ctr_next,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic [XLEN-1:0] pred_addr,
  output logic            flush,
  output logic [XLEN-1:0] flush_addr
);
  st_e             state_q;
  logic [4:0]      h_bo;
  logic [BIW-1:0]  h_bi;
  logic [1:0]      h_kind;
  logic [XLEN-1:0] h_pc, h_disp;
  logic            h_pred;

  logic            idle, accept, eval_en;
  logic [4:0]      a_bo;
  logic [BIW-1:0]  a_bi;
  br_kind_e        a_kind;
  logic [XLEN-1:0] a_pc, a_disp, fall, tgt, ctr_dec;
  bo_t             f;
  logic            taken, tgt_wait, cond_wait;

  assign idle    = (state_q == ST_IDLE);
  assign accept  = idle & issue_valid;
  assign eval_en = accept | ~idle;
  assign a_bo    = idle ? bo_raw   : h_bo;
  assign a_bi    = idle ? bi       : h_bi;
  assign a_kind  = br_kind_e'(idle ? kind : h_kind);
  assign a_pc    = idle ? fetch_pc : h_pc;
  assign a_disp  = idle ? disp     : h_disp;
  assign fall    = a_pc + XLEN'(IBYTES);

  cbr_bo_decode u_dec (.raw(a_bo), .f(f));

  cbr_cond_eval #(.XLEN(XLEN), .CRW(CRW)) u_eval (
    .f(f), .bi(a_bi), .cr(cr_bits), .ctr(ctr_val),
    .ctr_dec(ctr_dec), .taken(taken)
  );

  cbr_target_sel #(.XLEN(XLEN)) u_tgt (
    .kind(a_kind), .keep_ctr(f.keep_ctr), .pc(a_pc), .disp(a_disp),
    .lr(lr_val), .ctr(ctr_val), .ctr_dec(ctr_dec), .tgt(tgt)
  );

  assign tgt_wait  = ((a_kind == BK_LNK) & ~lr_ready) |
                     ((a_kind == BK_CNT) & ~ctr_ready);
  assign cond_wait = (~f.skip_cond & ~cr_ready) | (~f.keep_ctr & ~ctr_ready);

  assign busy  = ~idle;
  assign stall = (state_q == ST_TGT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      h_bo       <= '0;
      h_bi       <= '0;
      h_kind     <= '0;
      h_pc       <= '0;
      h_disp     <= '0;
      h_pred     <= 1'b0;
      res_valid  <= 1'b0;
      res_taken  <= 1'b0;
      res_target <= '0;
      ctr_we     <= 1'b0;
      ctr_next   <= '0;
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      pred_addr  <= '0;
      flush      <= 1'b0;
      flush_addr <= '0;
    end else begin
      res_valid  <= 1'b0;
      ctr_we     <= 1'b0;
      pred_valid <= 1'b0;
      flush      <= 1'b0;
      if (accept) begin
        h_bo   <= bo_raw;
        h_bi   <= bi;
        h_kind <= kind;
        h_pc   <= fetch_pc;
        h_disp <= disp;
      end
      if (eval_en) begin
        if (tgt_wait) begin
          state_q <= ST_TGT;
        end else if (cond_wait) begin
          if (state_q != ST_PRED) begin
            pred_valid <= 1'b1;
            pred_taken <= f.hint;
            pred_addr  <= f.hint ? tgt : fall;
            h_pred     <= f.hint;
          end
          state_q <= ST_PRED;
        end else begin
          res_valid  <= 1'b1;
          res_taken  <= taken;
          res_target <= tgt;
          ctr_we     <= ~f.keep_ctr;
          ctr_next   <= ctr_dec;
          flush      <= (state_q == ST_PRED) && (taken != h_pred);
          flush_addr <= taken ? tgt : fall;
          state_q    <= ST_IDLE;
        end
      end
    end
  end

  p_ctr_we_with_result_r2: assert property (@(posedge clk) disable iff (rst)
    ctr_we |-> res_valid);
  p_target_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_target[1:0] == 2'b00));
  p_result_frees_unit_r6: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !busy);
  p_pred_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    pred_valid |=> !pred_valid);
  p_no_guess_while_stalled_r8: assert property (@(posedge clk) disable iff (rst)
    stall |-> !pred_valid);
  p_flush_with_result_r9: assert property (@(posedge clk) disable iff (rst)
    flush |-> res_valid && $past(state_q == ST_PRED));
endmodule

// File: tb/sim_cbr_unit.sv
`timescale 1ns/1ps
module sim_cbr_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        issue_valid;
  logic [4:0]  bo_raw, bi;
  logic [1:0]  kind;
  logic [31:0] fetch_pc, disp, cr_bits, ctr_val, lr_val;
  logic        cr_ready, ctr_ready, lr_ready;
  logic        busy, stall, res_valid, res_taken, ctr_we, pred_valid, pred_taken, flush;
  logic [31:0] res_target, ctr_next, pred_addr, flush_addr;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  cbr_unit u0 (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .bo_raw(bo_raw), .bi(bi),
    .kind(kind), .fetch_pc(fetch_pc), .disp(disp), .cr_bits(cr_bits),
    .cr_ready(cr_ready), .ctr_val(ctr_val), .ctr_ready(ctr_ready),
    .lr_val(lr_val), .lr_ready(lr_ready), .busy(busy), .stall(stall),
    .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
    .ctr_we(ctr_we), .ctr_next(ctr_next), .pred_valid(pred_valid),
    .pred_taken(pred_taken), .pred_addr(pred_addr), .flush(flush),
    .flush_addr(flush_addr)
  );

  typedef struct packed {
    logic [4:0]  bo;
    logic [4:0]  bix;
    logic [1:0]  kd;
    logic [31:0] cr;
    logic [31:0] ctr;
    logic        tk;
    logic [31:0] tgt;
    logic        we;
    logic [31:0] cn;
    int          req;
  } vec_t;

  // pc=0x1000 disp=0x40 lr=0x2003, all ready
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{5'b10100, 5'd0,  2'd0, 32'h0,        32'd5,      1'b1, 32'h1040, 1'b0, 32'd0,      1}, // R1 always
    '{5'b01100, 5'd3,  2'd0, 32'h8,        32'd5,      1'b1, 32'h1040, 1'b0, 32'd0,      1}, // R1 true hit
    '{5'b01100, 5'd3,  2'd0, 32'h0,        32'd5,      1'b0, 32'h1040, 1'b0, 32'd0,      1}, // R1 true miss
    '{5'b00100, 5'd3,  2'd1, 32'h0,        32'd5,      1'b1, 32'h2000, 1'b0, 32'd0,      4}, // R4 link aligned
    '{5'b10000, 5'd0,  2'd0, 32'h0,        32'd5,      1'b1, 32'h1040, 1'b1, 32'd4,      2}, // R2 nonzero
    '{5'b10010, 5'd0,  2'd0, 32'h0,        32'd1,      1'b1, 32'h1040, 1'b1, 32'd0,      2}, // R2 zero hit
    '{5'b10010, 5'd0,  2'd0, 32'h0,        32'd5,      1'b0, 32'h1040, 1'b1, 32'd4,      2}, // R2 zero miss
    '{5'b10000, 5'd0,  2'd2, 32'h0,        32'h2006,   1'b1, 32'h2004, 1'b1, 32'h2005,   5}, // R5
    '{5'b11110, 5'd0,  2'd0, 32'h0,        32'd0,      1'b1, 32'h1040, 1'b0, 32'd0,      3}, // R3
    '{5'b11100, 5'd3,  2'd0, 32'h0,        32'd5,      1'b1, 32'h1040, 1'b0, 32'd0,      3}, // R3
    '{5'b00110, 5'd3,  2'd0, 32'h0,        32'd5,      1'b1, 32'h1040, 1'b0, 32'd0,      3}, // R3
    '{5'b00100, 5'd31, 2'd2, 32'h7FFFFFFF, 32'h3007,   1'b1, 32'h3004, 1'b0, 32'd0,      4}, // R4 count
    '{5'b01000, 5'd31, 2'd0, 32'h80000000, 32'd1,      1'b0, 32'h1040, 1'b1, 32'd0,      2}  // R2 both tests
  };

  task automatic chk(input string what, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [4:0] b, input logic [4:0] i, input logic [1:0] k);
    bo_raw = b; bi = i; kind = k; issue_valid = 1'b1;
    step();
    issue_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; issue_valid = 1'b0; bo_raw = '0; bi = '0; kind = '0;
    fetch_pc = 32'h1000; disp = 32'h40; lr_val = 32'h2003;
    cr_bits = '0; ctr_val = 32'd5; cr_ready = 1'b1; ctr_ready = 1'b1; lr_ready = 1'b1;
    @(negedge clk); step(); step();
    rst = 1'b0;
    step();
    // R10 reset state
    chk("busy", "R10", 32'(busy), 0);
    chk("stall", "R10", 32'(stall), 0);
    chk("res_valid", "R10", 32'(res_valid), 0);
    chk("pred_valid", "R10", 32'(pred_valid), 0);
    chk("ctr_we", "R10", 32'(ctr_we), 0);
    chk("flush", "R10", 32'(flush), 0);

    for (int n = 0; n < NV; n++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[n].req);
      cr_bits = VECS[n].cr; ctr_val = VECS[n].ctr;
      issue(VECS[n].bo, VECS[n].bix, VECS[n].kd);
      chk("res_valid R6", tag, 32'(res_valid), 1);
      chk("pred_valid R6", tag, 32'(pred_valid), 0);
      chk("taken", tag, 32'(res_taken), 32'(VECS[n].tk));
      chk("target", tag, res_target, VECS[n].tgt);
      chk("ctr_we", tag, 32'(ctr_we), 32'(VECS[n].we));
      if (VECS[n].we) chk("ctr_next", tag, ctr_next, VECS[n].cn);
      step();
      chk("res pulse R6", tag, 32'(res_valid), 0);
    end

    // R7 + R9: guess taken, correct
    ctr_val = 32'd5; cr_bits = 32'h0; cr_ready = 1'b0;
    issue(5'b01101, 5'd3, 2'd0);
    chk("pred_valid", "R7", 32'(pred_valid), 1);
    chk("pred_taken", "R7", 32'(pred_taken), 1);
    chk("pred_addr", "R7", pred_addr, 32'h1040);
    chk("res_valid pending", "R7", 32'(res_valid), 0);
    chk("busy", "R7", 32'(busy), 1);
    cr_bits = 32'h8; cr_ready = 1'b1;
    step();
    chk("res_valid", "R9", 32'(res_valid), 1);
    chk("taken", "R9", 32'(res_taken), 1);
    chk("no flush", "R9", 32'(flush), 0);
    step();

    // R9: guess not taken, resolves taken
    cr_bits = 32'h0; cr_ready = 1'b0;
    issue(5'b01100, 5'd3, 2'd0);
    chk("pred_taken", "R7", 32'(pred_taken), 0);
    chk("pred_addr fall", "R7", pred_addr, 32'h1004);
    cr_bits = 32'h8; cr_ready = 1'b1;
    step();
    chk("res_valid", "R9", 32'(res_valid), 1);
    chk("flush", "R9", 32'(flush), 1);
    chk("flush_addr", "R9", flush_addr, 32'h1040);
    step();
    chk("flush pulse", "R9", 32'(flush), 0);

    // R9: guess taken, resolves not taken
    cr_bits = 32'h0; cr_ready = 1'b0;
    issue(5'b01101, 5'd3, 2'd0);
    cr_ready = 1'b1;
    step();
    chk("taken", "R9", 32'(res_taken), 0);
    chk("flush", "R9", 32'(flush), 1);
    chk("flush_addr", "R9", flush_addr, 32'h1004);
    step();

    // R8: link target not ready, condition not ready either
    cr_bits = 32'h0; cr_ready = 1'b0; lr_ready = 1'b0;
    issue(5'b01101, 5'd3, 2'd1);
    chk("stall", "R8", 32'(stall), 1);
    chk("no pred", "R8", 32'(pred_valid), 0);
    step();
    chk("stall held", "R8", 32'(stall), 1);
    chk("no pred held", "R8", 32'(pred_valid), 0);
    lr_ready = 1'b1;
    step();
    chk("stall released", "R8", 32'(stall), 0);
    chk("pred after target", "R7", 32'(pred_valid), 1);
    chk("pred_addr link", "R7", pred_addr, 32'h2000);
    cr_bits = 32'h8; cr_ready = 1'b1;
    step();
    chk("res_valid", "R8", 32'(res_valid), 1);
    chk("target", "R8", res_target, 32'h2000);
    chk("no flush", "R9", 32'(flush), 0);
    step();

    // R8 + R5: count target not ready, then resolve with decrement
    ctr_ready = 1'b0; ctr_val = 32'h100;
    issue(5'b10000, 5'd0, 2'd2);
    chk("stall count", "R8", 32'(stall), 1);
    chk("no pred count", "R8", 32'(pred_valid), 0);
    ctr_ready = 1'b1;
    step();
    chk("res_valid", "R8", 32'(res_valid), 1);
    chk("target", "R5", res_target, 32'hFC);
    chk("ctr_next", "R5", ctr_next, 32'hFF);
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule